// File: doc/BRIEF.md
# Crosspoint Routing I/O Cell

This block is one output cell of a programmable digital crosspoint switch. It sees the whole signal routing pool as a flat input vector, split into four equal groups. A static setup, written through a small synchronous write port and then committed, picks one pool bit from each group. A 2-bit run-time select then chooses among those four bits on every cycle.

Cells can be daisy-chained. In chain mode each cell carries a 2-bit position number. A cell passes its own 4:1 result when the shared upper select equals its position. Otherwise it forwards the value arriving from the cell before it. Four chained cells therefore form a 16:1 multiplexer.

The chosen bit then passes through a pass-through, transparent-latch or edge-register stage. The gate and enable of that stage each come from a selectable control line. The output drive enable has programmable polarity. A constant mode ties the output to a fixed 0 or 1 and turns the driver on, so the cell can stand in for a jumper or a DIP switch. Until the setup is committed, the driver stays off.

Top module: `xpt_io_cell`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) clears all setup fields and the committed flag. A write with cfg_we high updates the addressed field at the clock edge. Addresses 0 to 3 hold the source index of groups A to D in wdata[1:0]. Address 4 holds stage mode [1:0], chain enable [2], chain position [4:3], enable polarity [5], constant enable [6] and constant value [7]. Address 5 holds the gate source [2:0] and the enable source [5:3]. Address 7 sets the committed flag to wdata[0].
- R2: Group g occupies pool bits [4g+3:4g], and its source index picks the bit within that group. Outside chain mode, dyn_sel 0, 1, 2 and 3 choose the bits selected from groups A, B, C and D.
- R3: In chain mode, the cell's result is its own 4:1 result when casc_sel equals its chain position, and chain_in otherwise. chain_out always carries this result.
- R4: In stage modes 0 and 3, pad_o follows the result in the same cycle.
- R5: In stage mode 2, pad_o shows a register. The register loads the result at a clock edge when both the selected gate line and the selected enable line are high. Otherwise it holds. Reset clears it to 0.
- R6: In stage mode 1, pad_o follows the result while the gate and enable lines are both high. Otherwise it shows the last value captured at a clock edge during that open phase.
- R7: The gate and enable source codes map as follows: 0 to 3 select gclk_line[0..3], 4 selects pin_ctl[0], 5 selects pin_ctl[1], and 6 and 7 mean always high.
- R8: Once committed and not in constant mode, pad_oe equals oe_in when the polarity bit is 1, and the inverse of oe_in when it is 0.
- R9: In constant mode, pad_o equals the constant value whatever the routed data. Once committed, pad_oe is 1.
- R10: While the committed flag is clear, including from reset until the first commit, pad_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_addr | input | 3 | Setup field address |
| cfg_wdata | input | 8 | Setup write data |
| pool | input | 16 | Routing pool, four groups of four bits |
| dyn_sel | input | 2 | Run-time 4:1 select |
| casc_sel | input | 2 | Shared upper select for chained cells |
| chain_in | input | 1 | Result of the previous chained cell |
| gclk_line | input | 4 | Global gate/enable lines |
| pin_ctl | input | 2 | Pin-derived gate/enable lines |
| oe_in | input | 1 | Raw drive enable |
| chain_out | output | 1 | Routed result toward the next cell |
| pad_o | output | 1 | Output data |
| pad_oe | output | 1 | Output driver enable |

## Verification
The storage assertions assume that the setup does not change in the cycle they look across, so they are gated off whenever cfg_we is high. The bench writes setup only in dedicated cycles, separate from the data phases. The chain-mode reference assumes the upstream cells hold source index k in every group and position k. The bench configures all four chained cells that way before it sweeps the 16 select values. All inputs change on the falling edge, so the gate and enable lines stay steady across each rising edge.

// File: rtl/xpt_io_cell.sv
module xpt_io_cell #(
  parameter int GRP_W  = 16,
  parameter int CFG_AW = 3,
  parameter int CFG_DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [GRP_W-1:0]  pool,
  input  logic [1:0]        dyn_sel,
  input  logic [1:0]        casc_sel,
  input  logic              chain_in,
  input  logic [3:0]        gclk_line,
  input  logic [1:0]        pin_ctl,
  input  logic              oe_in,
  output logic              chain_out,
  output logic              pad_o,
  output logic              pad_oe
);
  localparam int GW = GRP_W / 4;
  localparam int IW = (GW > 1) ? $clog2(GW) : 1;

  typedef enum logic [1:0] {M_COMB = 2'd0, M_LATCH = 2'd1, M_REG = 2'd2, M_PASS = 2'd3} mode_t;

  logic [IW-1:0] src_q [4];
  mode_t         mode_q;
  logic          casc_q, pol_q, frc_q, fval_q, valid_q;
  logic [1:0]    idx_q;
  logic [2:0]    gsrc_q, esrc_q;
  logic          q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '{default: '0};
      mode_q  <= M_COMB;
      casc_q  <= 1'b0;
      idx_q   <= 2'd0;
      pol_q   <= 1'b0;
      frc_q   <= 1'b0;
      fval_q  <= 1'b0;
      gsrc_q  <= 3'd0;
      esrc_q  <= 3'd0;
      valid_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_AW'(0), CFG_AW'(1), CFG_AW'(2), CFG_AW'(3):
          src_q[cfg_addr[1:0]] <= cfg_wdata[IW-1:0];
        CFG_AW'(4): begin
          mode_q <= mode_t'(cfg_wdata[1:0]);
          casc_q <= cfg_wdata[2];
          idx_q  <= cfg_wdata[4:3];
          pol_q  <= cfg_wdata[5];
          frc_q  <= cfg_wdata[6];
          fval_q <= cfg_wdata[7];
        end
        CFG_AW'(5): begin
          gsrc_q <= cfg_wdata[2:0];
          esrc_q <= cfg_wdata[5:3];
        end
        CFG_AW'(7): valid_q <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  logic [3:0] grp_bit;
  for (genvar g = 0; g < 4; g++) begin : g_grp
    assign grp_bit[g] = pool[g*GW + int'(src_q[g])];
  end

  logic own_res, mux_res;
  assign own_res   = grp_bit[dyn_sel];
  assign mux_res   = (casc_q && casc_sel != idx_q) ? chain_in : own_res;
  assign chain_out = mux_res;

  logic tick, ena, gate;
  assign tick = gsrc_q[2] ? (gsrc_q[1] ? 1'b1 : pin_ctl[gsrc_q[0]]) : gclk_line[gsrc_q[1:0]];
  assign ena  = esrc_q[2] ? (esrc_q[1] ? 1'b1 : pin_ctl[esrc_q[0]]) : gclk_line[esrc_q[1:0]];
  assign gate = tick & ena;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (gate) q <= mux_res;
  end

  logic stage;
  always_comb begin
    case (mode_q)
      M_LATCH: stage = gate ? mux_res : q;
      M_REG:   stage = q;
      default: stage = mux_res;
    endcase
  end

  assign pad_o  = frc_q ? fval_q : stage;
  assign pad_oe = valid_q & (frc_q | (pol_q ? oe_in : ~oe_in));

  AST_DARK_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) !valid_q |-> !pad_oe); // R10
  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_REG && !frc_q && gate && !cfg_we) |=> (pad_o == $past(chain_out))); // R5
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_REG && !frc_q && !gate && !cfg_we) |=> $stable(pad_o)); // R5
  AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_LATCH && !frc_q && gate) |-> (pad_o == chain_out)); // R6
  AST_OE_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !frc_q && !pol_q) |-> (pad_oe != oe_in)); // R8
  AST_CONST_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_q && !cfg_we) |=> ($stable(pad_o) && pad_oe == valid_q)); // R9
  AST_CHAIN_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_q && casc_sel != idx_q) |-> (chain_out == chain_in)); // R3
endmodule

// File: tb/sim_xpt_io_cell.sv
module sim_xpt_io_cell;
  localparam int P = 20;

  logic clk = 1'b0;
  always #(P/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic [3:0]  we = '0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] pool = '0;
  logic [1:0]  dyn = '0, csel = '0;
  logic [3:0]  gl = '0;
  logic [1:0]  pc = '0;
  logic        oe = 1'b0;
  logic [3:0]  co, po, poe;

  xpt_io_cell u0 (.clk(clk), .rst_n(rst_n), .cfg_we(we[0]), .cfg_addr(addr), .cfg_wdata(wdata),
    .pool(pool), .dyn_sel(dyn), .casc_sel(csel), .chain_in(co[1]), .gclk_line(gl), .pin_ctl(pc),
    .oe_in(oe), .chain_out(co[0]), .pad_o(po[0]), .pad_oe(poe[0]));
  xpt_io_cell u1 (.clk(clk), .rst_n(rst_n), .cfg_we(we[1]), .cfg_addr(addr), .cfg_wdata(wdata),
    .pool(pool), .dyn_sel(dyn), .casc_sel(csel), .chain_in(co[2]), .gclk_line(gl), .pin_ctl(pc),
    .oe_in(oe), .chain_out(co[1]), .pad_o(po[1]), .pad_oe(poe[1]));
  xpt_io_cell u2 (.clk(clk), .rst_n(rst_n), .cfg_we(we[2]), .cfg_addr(addr), .cfg_wdata(wdata),
    .pool(pool), .dyn_sel(dyn), .casc_sel(csel), .chain_in(co[3]), .gclk_line(gl), .pin_ctl(pc),
    .oe_in(oe), .chain_out(co[2]), .pad_o(po[2]), .pad_oe(poe[2]));
  xpt_io_cell u3 (.clk(clk), .rst_n(rst_n), .cfg_we(we[3]), .cfg_addr(addr), .cfg_wdata(wdata),
    .pool(pool), .dyn_sel(dyn), .casc_sel(csel), .chain_in(1'b0), .gclk_line(gl), .pin_ctl(pc),
    .oe_in(oe), .chain_out(co[3]), .pad_o(po[3]), .pad_oe(poe[3]));

  int m_src [4] = '{0, 0, 0, 0};
  int m_mode = 0, m_idx = 0, m_gs = 0, m_es = 0;
  bit m_casc = 0, m_pol = 0, m_frc = 0, m_fval = 0, m_valid = 0, m_q = 0;
  int checks = 0, errors = 0;

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit line(int s);
    if (s < 4) return gl[s];
    if (s == 4) return pc[0];
    if (s == 5) return pc[1];
    return 1'b1;
  endfunction

  function automatic bit exp_res();
    if (m_casc && int'(csel) != m_idx) return pool[int'(dyn)*4 + int'(csel)];
    return pool[int'(dyn)*4 + m_src[dyn]];
  endfunction

  function automatic bit exp_pad();
    bit g = line(m_gs) & line(m_es);
    if (m_frc) return m_fval;
    if (m_mode == 2) return m_q;
    if (m_mode == 1) return g ? exp_res() : m_q;
    return exp_res();
  endfunction

  function automatic bit exp_oe();
    return m_valid && (m_frc || (m_pol ? oe : !oe));
  endfunction

  task automatic step(string req);
    bit g, r;
    #1;
    chk(req, po[0], exp_pad());
    chk(req, poe[0], exp_oe());
    chk(req, co[0], exp_res());
    g = line(m_gs) & line(m_es);
    r = exp_res();
    @(posedge clk);
    if (!rst_n) begin
      m_src = '{0, 0, 0, 0};
      m_mode = 0; m_idx = 0; m_gs = 0; m_es = 0;
      m_casc = 0; m_pol = 0; m_frc = 0; m_fval = 0; m_valid = 0; m_q = 0;
    end else begin
      if (g) m_q = r;
      if (we[0]) begin
        case (int'(addr))
          0, 1, 2, 3: m_src[addr] = int'(wdata[1:0]);
          4: begin
            m_mode = int'(wdata[1:0]); m_casc = wdata[2]; m_idx = int'(wdata[4:3]);
            m_pol = wdata[5]; m_frc = wdata[6]; m_fval = wdata[7];
          end
          5: begin m_gs = int'(wdata[2:0]); m_es = int'(wdata[5:3]); end
          7: m_valid = wdata[0];
          default: ;
        endcase
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] mask, int a, int d, string req);
    we = mask; addr = 3'(a); wdata = 8'(d);
    step(req);
    we = '0;
  endtask

  task automatic rnd_in();
    pool = 16'($urandom); dyn = 2'($urandom); gl = 4'($urandom);
    pc = 2'($urandom); oe = 1'($urandom);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(P * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R1 reset");
    rst_n = 1'b1;
    oe = 1'b1;
    step("R10 dark after reset");
    for (int a = 0; a < 4; a++) wr(4'b0001, a, 3 - a, "R1 src write");
    wr(4'b0001, 4, 8'h20, "R1 mode write");
    for (int i = 0; i < 6; i++) begin rnd_in(); step("R10 dark before commit"); end
    wr(4'b0001, 7, 1, "R1 commit");
    for (int i = 0; i < 40; i++) begin rnd_in(); step("R2 R4 R8 comb routing"); end
    for (int a = 0; a < 4; a++) wr(4'b0001, a, int'($urandom_range(0, 3)), "R2 new sources");
    wr(4'b0001, 4, 8'h03, "R8 polarity low");
    for (int i = 0; i < 30; i++) begin rnd_in(); step("R4 R8 pass mode inverted enable"); end
    for (int k = 0; k < 8; k++) begin
      wr(4'b0001, 4, 8'h22, "R5 register mode");
      wr(4'b0001, 5, int'($urandom_range(0, 63)), "R7 source codes");
      for (int i = 0; i < 12; i++) begin rnd_in(); step("R5 R7 register"); end
    end
    for (int k = 0; k < 8; k++) begin
      wr(4'b0001, 4, 8'h21, "R6 latch mode");
      wr(4'b0001, 5, int'($urandom_range(0, 63)), "R7 source codes");
      for (int i = 0; i < 12; i++) begin rnd_in(); step("R6 R7 latch"); end
    end
    wr(4'b0001, 4, 8'hC0, "R9 constant high");
    for (int i = 0; i < 8; i++) begin rnd_in(); oe = 1'b0; step("R9 constant high"); end
    wr(4'b0001, 4, 8'h40, "R9 constant low");
    for (int i = 0; i < 8; i++) begin rnd_in(); step("R9 constant low"); end
    wr(4'b0001, 7, 0, "R1 uncommit");
    for (int i = 0; i < 4; i++) begin rnd_in(); step("R10 dark after uncommit"); end
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 4; a++) wr(4'(1 << k), a, k, "R3 chain sources");
      wr(4'(1 << k), 4, 32'h24 | (k << 3), "R3 chain mode");
      wr(4'(1 << k), 7, 1, "R3 chain commit");
    end
    for (int v = 0; v < 16; v++) begin
      for (int r = 0; r < 2; r++) begin
        pool = 16'($urandom); csel = 2'(v >> 2); dyn = 2'(v); oe = 1'b1;
        step("R3 cascaded 16:1");
        chk("R3 16:1 bit", po[0], pool[(v % 4) * 4 + v / 4]);
      end
    end
    wr(4'b0001, 4, 8'h22, "R5 register mode");
    wr(4'b0001, 5, 8'h3F, "R7 always open");
    pool = 16'hFFFF;
    step("R5 load one");
    rst_n = 1'b0;
    step("R5 reset during run");
    rst_n = 1'b1;
    step("R1 R5 reset clears state");
    summary();
    $finish;
  end
endmodule